// File: doc/BRIEF.md
# Clock Output Enable Controller

This block sits between eight already-generated clock sources and the output pads of a clock generator. It decides, for each output, whether the pad carries a clock or sits in a disabled state. There are three ways to stop an output. Four individual enable pins each control one even-numbered output. A master enable controls all outputs. An active-low power-up input also stops all outputs. A single static mode bit decides what a disabled output does: it either floats (drive enable low) or is driven to a steady low level.

Enable changes are first brought into each output's own clock domain. They then take effect only while that clock is low, so the pad never shows a shortened high pulse. Output 2 can take either its own source or the source of output 1. The choice goes through a handshaked, glitch-free two-way clock switch. A 2-bit configuration select is synchronised into the control clock domain and presented as a configuration index. Its reset value is the all-ones index.

Top module: `clkout_bank_ctrl`

## Requirements
- R1: Enable pin bit k (k = 0..3) gates output 2k: at 1 the output runs, at 0 it goes to the disabled state. Odd-numbered outputs have no individual pin and run whenever the master enable and power-up inputs are both high.
- R2: A disabled output always has its level at 0. Its drive enable is 0 when `drive_low_i` is 0 (float) and 1 when `drive_low_i` is 1 (driven low). An enabled output has drive enable 1 and carries its clock.
- R3: With `master_en_i` low, all eight outputs are in the disabled state within 16 control clock cycles.
- R4: With `pwr_on_i` low, all eight outputs are in the disabled state within 16 control clock cycles.
- R5: `cfg_idx_o` equals the value that `cfg_sel_i` had two `ctl_clk_i` rising edges earlier. Codes 0..3 map to configurations 0..3.
- R6: With `fsel_alt_i` = 1, output 2 carries the source of output 1 and `out2_alt_o` is 1. With `fsel_alt_i` = 0, output 2 carries its own source and `out2_alt_o` is 0.
- R7: Enabling or disabling an output never produces a high pulse shorter or longer than a full high phase of its source.
- R8: After an enable input rises, the output shows its first rising edge within four periods of its source clock.
- R9: While output 2 switches between its two sources, no high or low phase is shorter than the shorter half-period of the two sources, and the two switch branches are never active together.
- R10: During reset every output is in the disabled state given by `drive_low_i`, and `cfg_idx_o` is 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous active-low reset |
| ctl_clk_i | input | 1 | Control clock for the configuration index |
| src_clk_i | input | 8 | Source clock for each output |
| out_en_pin_i | input | 4 | Individual enables; bit k gates output 2k |
| master_en_i | input | 1 | Master enable for all outputs |
| pwr_on_i | input | 1 | Active-low power-down; low stops all outputs |
| drive_low_i | input | 1 | Disabled state: 0 float, 1 driven low |
| cfg_sel_i | input | 2 | Configuration select |
| fsel_alt_i | input | 1 | 1: output 2 takes output 1's source |
| clk_oe_o | output | 8 | Pad drive enable per output |
| clk_lvl_o | output | 8 | Pad level per output |
| cfg_idx_o | output | 2 | Synchronised configuration index |
| out2_alt_o | output | 1 | Output 2 currently driven by output 1's source |

## Verification
The assertions assume that the source clocks keep toggling while an output is being stopped. They also assume that `fsel_alt_i` stays stable for many source periods after each change, because a select that flips back before the handshake completes could start both switch branches. The stimulus changes every control input at least 70 ns apart. It never gates the source clocks. It always changes inputs half a nanosecond away from any clock edge. Under these conditions, the quiet-window bound of 16 control cycles covers the slowest source, whose period is 20 ns.

// File: rtl/clkctl_pkg.sv
`timescale 1ns/100ps
package clkctl_pkg;
    localparam int SYNC_STAGES = 2;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] chain;
    } sync_chain_t;
endpackage

// File: rtl/clk_en_gate.sv
`timescale 1ns/100ps
module clk_en_gate
    import clkctl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic drive_low_i,
    output logic oe_o,
    output logic lvl_o
);
    sync_chain_t s_d, s_q;
    logic        en_d, en_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], run_i};
        en_d      = s_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    // enable moves only on the falling edge: the clock is low then
    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) en_q <= 1'b0;
        else         en_q <= en_d;
    end

    assign lvl_o = clk_i & en_q;
    assign oe_o  = en_q | drive_low_i;
endmodule

// File: rtl/clk_swap_leg.sv
`timescale 1ns/100ps
module clk_swap_leg
    import clkctl_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic want_i,
    input  logic other_on_i,
    output logic on_o,
    output logic gclk_o
);
    sync_chain_t s_d, s_q;
    logic        on_d, on_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[SYNC_STAGES-2:0], want_i & ~other_on_i};
        on_d      = s_q.chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    always_ff @(negedge clk_i or negedge rst_ni) begin
        if (!rst_ni) on_q <= 1'b0;
        else         on_q <= on_d;
    end

    assign on_o   = on_q;
    assign gclk_o = clk_i & on_q;
endmodule

// File: rtl/clk_swap_mux.sv
`timescale 1ns/100ps
module clk_swap_mux (
    input  logic clk_alt_i,
    input  logic clk_own_i,
    input  logic rst_ni,
    input  logic pick_alt_i,
    output logic clk_o,
    output logic alt_on_o,
    output logic own_on_o
);
    logic g_alt, g_own;

    clk_swap_leg u_alt (
        .clk_i      (clk_alt_i),
        .rst_ni     (rst_ni),
        .want_i     (pick_alt_i),
        .other_on_i (own_on_o),
        .on_o       (alt_on_o),
        .gclk_o     (g_alt)
    );

    clk_swap_leg u_own (
        .clk_i      (clk_own_i),
        .rst_ni     (rst_ni),
        .want_i     (~pick_alt_i),
        .other_on_i (alt_on_o),
        .on_o       (own_on_o),
        .gclk_o     (g_own)
    );

    assign clk_o = g_alt | g_own;
endmodule

// File: rtl/clkout_bank_ctrl.sv
`timescale 1ns/100ps
module clkout_bank_ctrl #(
    parameter  int N_OUT    = 8,
    parameter  int CFG_W    = 2,
    parameter  int SWAP_DST = 2,
    parameter  int SWAP_SRC = 1,
    localparam int N_PIN    = N_OUT / 2
) (
    input  logic             rst_ni,
    input  logic             ctl_clk_i,
    input  logic [N_OUT-1:0] src_clk_i,
    input  logic [N_PIN-1:0] out_en_pin_i,
    input  logic             master_en_i,
    input  logic             pwr_on_i,
    input  logic             drive_low_i,
    input  logic [CFG_W-1:0] cfg_sel_i,
    input  logic             fsel_alt_i,
    output logic [N_OUT-1:0] clk_oe_o,
    output logic [N_OUT-1:0] clk_lvl_o,
    output logic [CFG_W-1:0] cfg_idx_o,
    output logic             out2_alt_o
);
    typedef struct packed {
        logic [CFG_W-1:0] meta;
        logic [CFG_W-1:0] held;
    } cfg_sync_t;

    cfg_sync_t cfg_d, cfg_q;
    logic      swap_clk;
    logic      sw_alt_on, sw_own_on;

    always_comb begin
        cfg_d      = cfg_q;
        cfg_d.meta = cfg_sel_i;
        cfg_d.held = cfg_q.meta;
    end

    always_ff @(posedge ctl_clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '{meta: '1, held: '1};
        else         cfg_q <= cfg_d;
    end

    assign cfg_idx_o = cfg_q.held;

    clk_swap_mux u_swap (
        .clk_alt_i  (src_clk_i[SWAP_SRC]),
        .clk_own_i  (src_clk_i[SWAP_DST]),
        .rst_ni     (rst_ni),
        .pick_alt_i (fsel_alt_i),
        .clk_o      (swap_clk),
        .alt_on_o   (sw_alt_on),
        .own_on_o   (sw_own_on)
    );

    assign out2_alt_o = sw_alt_on;

    for (genvar i = 0; i < N_OUT; i++) begin : g_out
        logic run;
        logic gclk;

        if (i % 2 == 0) begin : g_pin
            assign run = master_en_i & pwr_on_i & out_en_pin_i[i/2];
        end else begin : g_free
            assign run = master_en_i & pwr_on_i;
        end

        if (i == SWAP_DST) begin : g_sw
            assign gclk = swap_clk;
        end else begin : g_dir
            assign gclk = src_clk_i[i];
        end

        clk_en_gate u_gate (
            .clk_i       (gclk),
            .rst_ni      (rst_ni),
            .run_i       (run),
            .drive_low_i (drive_low_i),
            .oe_o        (clk_oe_o[i]),
            .lvl_o       (clk_lvl_o[i])
        );
    end
endmodule

// File: rtl/clkout_bank_ctrl_chk.sv
`timescale 1ns/100ps
module clkout_bank_ctrl_chk #(
    parameter int N_OUT     = 8,
    parameter int CFG_W     = 2,
    parameter int QUIET_LAT = 16
) (
    input logic             rst_ni,
    input logic             ctl_clk_i,
    input logic             master_en_i,
    input logic             pwr_on_i,
    input logic             drive_low_i,
    input logic [CFG_W-1:0] cfg_sel_i,
    input logic [CFG_W-1:0] cfg_idx_o,
    input logic [N_OUT-1:0] clk_oe_o,
    input logic [N_OUT-1:0] clk_lvl_o,
    input logic             sw_alt_on,
    input logic             sw_own_on
);
    localparam int CW = $clog2(QUIET_LAT + 1);

    logic [1:0]    since_rst;
    logic [CW-1:0] m_off_cnt, p_off_cnt;

    always_ff @(posedge ctl_clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst <= '0;
            m_off_cnt <= '0;
            p_off_cnt <= '0;
        end else begin
            if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
            if (master_en_i) m_off_cnt <= '0;
            else if (m_off_cnt != CW'(QUIET_LAT)) m_off_cnt <= m_off_cnt + 1'b1;
            if (pwr_on_i) p_off_cnt <= '0;
            else if (p_off_cnt != CW'(QUIET_LAT)) p_off_cnt <= p_off_cnt + 1'b1;
        end
    end

    AST_DRIVE_LOW_ALWAYS_DRIVEN: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
        drive_low_i |-> (clk_oe_o == '1)); // R2

    AST_MASTER_OFF_QUIET: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
        (m_off_cnt == CW'(QUIET_LAT)) |-> (clk_lvl_o == '0)); // R3

    AST_PWR_OFF_QUIET: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
        (p_off_cnt == CW'(QUIET_LAT)) |-> (clk_lvl_o == '0)); // R4

    AST_CFG_TWO_EDGE_LAG: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
        (since_rst == 2'd2) |-> (cfg_idx_o == $past(cfg_sel_i, 2))); // R5

    AST_SWAP_LEGS_EXCLUSIVE: assert property (@(posedge ctl_clk_i) disable iff (!rst_ni)
        $onehot0({sw_alt_on, sw_own_on})); // R9
endmodule

bind clkout_bank_ctrl clkout_bank_ctrl_chk #(.N_OUT(N_OUT), .CFG_W(CFG_W)) chk_i (.*);

// File: tb/clkout_bank_ctrl_tb.sv
`timescale 1ns/100ps
module clkout_bank_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HP_BASE    = 3;
    localparam int WIN        = 240;
    localparam int WD_NS      = 200000;
    localparam int NV         = 9;
    // {pins[3:0], master, pwr_on, drive_low, fsel, cfg[1:0]}
    localparam logic [9:0] VEC [NV] = '{
        10'b1111_1_1_0_1_11,
        10'b1111_1_1_0_0_00,
        10'b0101_1_1_0_1_01,
        10'b1010_1_1_1_0_10,
        10'b1111_0_1_0_1_11,
        10'b1111_0_1_1_0_01,
        10'b1111_1_0_1_1_10,
        10'b0000_1_0_0_0_00,
        10'b0000_1_1_1_1_11
    };

    logic       rst_n = 1'b0;
    logic       ctl_clk = 1'b0;
    logic [7:0] src_clk;
    logic [3:0] pins = 4'hF;
    logic       master = 1'b1, pwr = 1'b1, dlow = 1'b0, fsel = 1'b1;
    logic [1:0] cfg = 2'b00;
    logic [7:0] oe, lvl;
    logic [1:0] cfg_idx;
    logic       alt;

    int n_chk  = 0;
    int n_fail = 0;

    initial forever #(CLK_PERIOD/2) ctl_clk = ~ctl_clk;

    for (genvar g = 0; g < 8; g++) begin : g_src
        logic c = 1'b0;
        initial forever #(HP_BASE + g) c = ~c;
        assign src_clk[g] = c;
    end

    clkout_bank_ctrl dut_i (
        .rst_ni       (rst_n),
        .ctl_clk_i    (ctl_clk),
        .src_clk_i    (src_clk),
        .out_en_pin_i (pins),
        .master_en_i  (master),
        .pwr_on_i     (pwr),
        .drive_low_i  (dlow),
        .cfg_sel_i    (cfg),
        .fsel_alt_i   (fsel),
        .clk_oe_o     (oe),
        .clk_lvl_o    (lvl),
        .cfg_idx_o    (cfg_idx),
        .out2_alt_o   (alt)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    // realign to half-nanosecond phase, away from every clock edge
    task automatic settle(input int n);
        @(posedge ctl_clk);
        #0.5;
        repeat (n) #1;
    endtask

    function automatic int src_period(input int i, input bit f);
        if (i == 2) return f ? 2*(HP_BASE+1) : 2*(HP_BASE+2);
        return 2*(HP_BASE+i);
    endfunction

    task automatic run_vec(input logic [9:0] v);
        int   edges [8];
        bit   hi_seen [8];
        bit   oe_bad [8];
        logic [7:0] prev;
        pins = v[9:6]; master = v[5]; pwr = v[4]; dlow = v[3]; fsel = v[2]; cfg = v[1:0];
        settle(300);
        for (int i = 0; i < 8; i++) begin edges[i] = 0; hi_seen[i] = 0; oe_bad[i] = 0; end
        prev = lvl;
        for (int s = 0; s < WIN; s++) begin
            for (int i = 0; i < 8; i++) begin
                if (lvl[i] && !prev[i]) edges[i]++;
                if (lvl[i]) hi_seen[i] = 1;
                if (oe[i] !== ((master && pwr && (i % 2 == 1 || pins[i/2])) ? 1'b1 : dlow))
                    oe_bad[i] = 1;
            end
            prev = lvl;
            #1;
        end
        for (int i = 0; i < 8; i++) begin
            bit    on  = master && pwr && (i % 2 == 1 || pins[i/2]);
            int    ex  = WIN / src_period(i, fsel);
            string tg  = !pwr ? "R4" : !master ? "R3" : (i == 2) ? "R6" : "R1";
            if (on)
                check(!oe_bad[i] && edges[i] >= ex-1 && edges[i] <= ex+1, tg,
                      $sformatf("output %0d running edges", i), edges[i], ex);
            else begin
                check(!hi_seen[i], tg, $sformatf("output %0d disabled edges", i), edges[i], 0);
                check(!oe_bad[i], "R2", $sformatf("output %0d disabled oe", i), oe[i], dlow);
            end
        end
        check(cfg_idx == v[1:0], "R5", "cfg index", cfg_idx, v[1:0]);
        check(alt == fsel, "R6", "out2 alt source flag", alt, fsel);
    endtask

    initial begin
        #(WD_NS);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        // R10 reset state, float mode then driven-low mode
        dlow = 1'b0; cfg = 2'b00;
        #20.5;
        check(oe == 8'h00, "R10", "reset oe float", oe, 0);
        check(lvl == 8'h00, "R10", "reset level", lvl, 0);
        check(cfg_idx == 2'd3, "R10", "reset cfg index", cfg_idx, 3);
        dlow = 1'b1;
        #1;
        check(oe == 8'hFF, "R2", "reset oe driven low", oe, 255);
        dlow = 1'b0;
        #2;
        rst_n = 1'b1;

        // table of vectors
        for (int v = 0; v < NV; v++) run_vec(VEC[v]);

        // R5 latency: two control edges
        pins = 4'hF; master = 1; pwr = 1; dlow = 0; fsel = 1; cfg = 2'b11;
        settle(50);
        cfg = 2'b01;
        @(posedge ctl_clk); #2;
        check(cfg_idx == 2'd3, "R5", "cfg after one edge", cfg_idx, 3);
        @(posedge ctl_clk); #2;
        check(cfg_idx == 2'd1, "R5", "cfg after two edges", cfg_idx, 1);

        // R7 / R8: toggle output 0 enable at irregular points
        begin
            int run_len = 0, high_runs = 0, first_rise = -1, bad = 0;
            logic pv;
            pins[0] = 0;
            settle(100);
            pv = lvl[0];
            for (int j = 0; j < 400; j++) begin
                if (j == 37 || j == 111 || j == 190 || j == 263) pins[0] = ~pins[0];
                if (lvl[0] != pv) begin
                    if (pv == 1'b1) begin
                        high_runs++;
                        check(run_len == HP_BASE, "R7", "output 0 high pulse width", run_len, HP_BASE);
                    end
                    if (lvl[0] && first_rise < 0) first_rise = j;
                    run_len = 0;
                end
                if (lvl[0] === 1'bx) bad++;
                run_len++;
                pv = lvl[0];
                #1;
            end
            check(high_runs >= 10 && bad == 0, "R7", "output 0 pulse count", high_runs, 10);
            check(first_rise > 37 && first_rise <= 37 + 4*2*HP_BASE, "R8",
                  "first rise after enable", first_rise, 37 + 4*2*HP_BASE);
            check(lvl[0] == 0 && oe[0] == 0, "R2", "output 0 parked float", lvl[0], 0);
        end

        // R9: switch output 2 between sources
        begin
            int run_len = 0, min_run = 1000, runs = 0;
            logic pv;
            pins = 4'hF; fsel = 1;
            settle(100);
            pv = lvl[2];
            for (int j = 0; j < 400; j++) begin
                if (j == 50 || j == 150 || j == 260) fsel = ~fsel;
                if (lvl[2] != pv) begin
                    if (runs > 0 && run_len < min_run) min_run = run_len;
                    runs++;
                    run_len = 0;
                end
                run_len++;
                pv = lvl[2];
                #1;
            end
            check(min_run >= HP_BASE + 1, "R9", "narrowest phase on output 2", min_run, HP_BASE + 1);
            check(runs > 40, "R9", "output 2 keeps running", runs, 40);
            settle(100);
            check(alt == 1'b0, "R6", "alt flag after final switch", alt, 0);
        end

        summary();
        $finish;
    end
endmodule